// File: doc/BRIEF.md
# Page Write Buffer With Self-Timed Commit

This block sits between a serial memory's command front end and its 32K x 8 storage array. When the front end decodes a write command, it passes in the target address. The block then collects each data byte into a one-page (64-byte) holding buffer. The write position starts at the low six address bits and advances modulo 64. The page number stays fixed for the whole command. If more than a page of bytes arrives, the position wraps and later bytes replace earlier ones.

When chip select rises, the block decides whether to commit. A commit starts only if all of these hold:
- the write-enable state was set when the command began;
- the rise fell on a byte boundary;
- at least one byte was loaded;
- the page lies outside the protected region.

During a commit the block sweeps the buffer once and issues an array write for every loaded offset. It holds a busy flag for a fixed number of clock cycles, which stands in for the self-timed programming interval. In its last busy cycle it pulses a request to clear the write-enable state. While busy, it refuses new write commands and their bytes.

Top module: `page_write_buf`

## Requirements
- R1: After reset `wip_o`, `arr_we_o` and `wel_clr_o` are 0.
- R2: Bytes are stored starting at offset `addr_i[5:0]` captured on an accepted `start_i`. The offset increments by one per byte and wraps 63 to 0. Every committed write address is `{addr_i[14:6], offset}` with the upper nine bits equal to the captured page.
- R3: When more than 64 bytes are loaded, each offset commits only the last byte loaded at it, and exactly 64 writes are issued.
- R4: A qualifying `cs_rise_i` pulse in cycle N makes `wip_o` high in cycle N+1. Writes then issue one offset per cycle in ascending order from offset 0, only for loaded offsets and only while `wip_o` is high.
- R5: `wip_o` stays high for exactly `COMMIT_CYCLES` consecutive cycles per commit.
- R6: `wel_clr_o` pulses once per commit, in the last cycle in which `wip_o` is high.
- R7: If `wen_i` was 0 in the cycle `start_i` was accepted, `cs_rise_i` starts no commit and the buffer is discarded.
- R8: If `aligned_i` is 0 with `cs_rise_i`, no commit starts and the buffer is discarded.
- R9: `prot_i` encoding: 0 protects nothing; 1 protects addresses with bits [14:13]=11; 2 protects addresses with bit 14=1; 3 protects everything. A write whose page is protected starts no commit and issues no array write.
- R10: `start_i`, `byte_vld_i` and `cs_rise_i` while `wip_o` is high are refused: they cause no array write, and no commit follows.
- R11: A byte strobed in the same cycle as `cs_rise_i` is loaded and included in that commit.
- R12: `cs_rise_i` with no byte loaded since `start_i` starts no commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Write command decoded; captures `addr_i` and `wen_i` |
| addr_i | input | ADDR_W | Start address of the write |
| wen_i | input | 1 | Write-enable state at command start |
| byte_vld_i | input | 1 | Data byte strobe |
| byte_i | input | DATA_W | Data byte |
| cs_rise_i | input | 1 | Chip-select rising event, one-cycle pulse |
| aligned_i | input | 1 | The rise came on a byte boundary |
| prot_i | input | 2 | Block-protect setting |
| arr_we_o | output | 1 | Array write strobe |
| arr_addr_o | output | ADDR_W | Array write address |
| arr_data_o | output | DATA_W | Array write data |
| wip_o | output | 1 | Commit in progress |
| wel_clr_o | output | 1 | Clear write-enable request, one cycle |

## Verification
Two events can land in the same cycle:
- The last data byte and the chip-select rise. The bench strobes one byte alone, then a second byte together with `cs_rise_i`. It expects both offsets to be written, proving the closing byte reaches the buffer before the commit sweep reads it.
- A new command and a running commit. The bench issues a full start, byte and rise sequence while the first commit is still busy. It expects the write log to hold only the first commit's single write and the busy count to equal one commit interval.

// File: rtl/pwb_pkg.sv
`timescale 1ns/1ps
package pwb_pkg;
  typedef enum logic [1:0] {
    PROT_NONE = 2'd0,
    PROT_QTR  = 2'd1,
    PROT_HALF = 2'd2,
    PROT_ALL  = 2'd3
  } prot_e;

  // top2 = two most significant address bits of the page
  function automatic logic prot_hit(prot_e p, logic [1:0] top2);
    case (p)
      PROT_NONE: return 1'b0;
      PROT_QTR:  return top2 == 2'b11;
      PROT_HALF: return top2[1];
      default:   return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/pwb_protect.sv
`timescale 1ns/1ps
module pwb_protect
  import pwb_pkg::*;
(
  input  logic [1:0] prot_i,
  input  logic [1:0] page_top_i,
  output logic       hit_o
);
  assign hit_o = prot_hit(prot_e'(prot_i), page_top_i);
endmodule

// File: rtl/pwb_buffer.sv
`timescale 1ns/1ps
module pwb_buffer #(
  parameter int PAGE_BYTES = 64,
  parameter int DATA_W     = 8,
  localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [OFF_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_vld_o,
  output logic              any_o
);
  logic [DATA_W-1:0]     mem_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] vld_q;
  logic [OFF_W-1:0]      ptr_q;

  always_ff @(posedge clk_i) begin
    if (wr_i && !load_i) mem_q[ptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      ptr_q <= '0;
    end else if (load_i) begin
      vld_q <= '0;
      ptr_q <= off_i;
    end else if (wr_i) begin
      vld_q[ptr_q] <= 1'b1;
      ptr_q        <= ptr_q + 1'b1; // wraps inside the page
    end
  end

  assign rd_data_o = mem_q[rd_idx_i];
  assign rd_vld_o  = vld_q[rd_idx_i];
  assign any_o     = |vld_q;
endmodule

// File: rtl/pwb_sequencer.sv
`timescale 1ns/1ps
module pwb_sequencer #(
  parameter int PAGE_BYTES    = 64,
  parameter int COMMIT_CYCLES = 250000,
  localparam int OFF_W        = $clog2(PAGE_BYTES),
  localparam int CNT_W        = $clog2(COMMIT_CYCLES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             wen_i,
  input  logic             cs_rise_i,
  input  logic             aligned_i,
  input  logic             pend_i,
  input  logic             hit_i,
  output logic             load_o,
  output logic             active_o,
  output logic             busy_o,
  output logic             sweep_o,
  output logic [OFF_W-1:0] idx_o,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] LAST      = CNT_W'(COMMIT_CYCLES - 1);
  localparam logic [CNT_W-1:0] SWEEP_END = CNT_W'(PAGE_BYTES);

  logic             active_q, wen_q, busy_q, go;
  logic [CNT_W-1:0] cnt_q;

  assign load_o   = start_i && !busy_q;
  assign go       = cs_rise_i && active_q && wen_q && aligned_i && pend_i && !hit_i;
  assign done_o   = busy_q && (cnt_q == LAST);
  assign sweep_o  = busy_q && (cnt_q < SWEEP_END);
  assign idx_o    = cnt_q[OFF_W-1:0];
  assign active_o = active_q;
  assign busy_o   = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      wen_q    <= 1'b0;
    end else if (load_o) begin
      active_q <= 1'b1;
      wen_q    <= wen_i;
    end else if (cs_rise_i) begin
      active_q <= 1'b0; // commit or discard, buffer closed either way
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (go) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (done_o) busy_q <= 1'b0;
      else        cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/page_write_buf.sv
`timescale 1ns/1ps
module page_write_buf #(
  parameter int ADDR_W        = 15,
  parameter int DATA_W        = 8,
  parameter int PAGE_BYTES    = 64,
  parameter int COMMIT_CYCLES = 250000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wen_i,
  input  logic              byte_vld_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              cs_rise_i,
  input  logic              aligned_i,
  input  logic [1:0]        prot_i,
  output logic              arr_we_o,
  output logic [ADDR_W-1:0] arr_addr_o,
  output logic [DATA_W-1:0] arr_data_o,
  output logic              wip_o,
  output logic              wel_clr_o
);
  localparam int OFF_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - OFF_W;

  logic [PAGE_W-1:0] page_q;
  logic              load, active, busy, sweep, done, wr, any, hit, rd_vld;
  logic [OFF_W-1:0]  idx;
  logic [DATA_W-1:0] rd_data;

  assign wr = byte_vld_i && active && !busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   page_q <= '0;
    else if (load) page_q <= addr_i[ADDR_W-1:OFF_W];
  end

  pwb_buffer #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W)) u_buf (
    .clk_i, .rst_ni,
    .load_i   (load),
    .off_i    (addr_i[OFF_W-1:0]),
    .wr_i     (wr),
    .data_i   (byte_i),
    .rd_idx_i (idx),
    .rd_data_o(rd_data),
    .rd_vld_o (rd_vld),
    .any_o    (any)
  );

  pwb_protect u_prot (
    .prot_i    (prot_i),
    .page_top_i(page_q[PAGE_W-1:PAGE_W-2]),
    .hit_o     (hit)
  );

  pwb_sequencer #(.PAGE_BYTES(PAGE_BYTES), .COMMIT_CYCLES(COMMIT_CYCLES)) u_seq (
    .clk_i, .rst_ni,
    .start_i, .wen_i, .cs_rise_i, .aligned_i,
    .pend_i  (any || wr), // closing byte in the rise cycle counts
    .hit_i   (hit),
    .load_o  (load),
    .active_o(active),
    .busy_o  (busy),
    .sweep_o (sweep),
    .idx_o   (idx),
    .done_o  (done)
  );

  assign arr_we_o   = sweep && rd_vld;
  assign arr_addr_o = {page_q, idx};
  assign arr_data_o = rd_data;
  assign wip_o      = busy;
  assign wel_clr_o  = done;
endmodule

// File: rtl/pwb_checks.sv
`timescale 1ns/1ps
module pwb_checks #(
  parameter int ADDR_W = 15,
  parameter int OFF_W  = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_rise_i,
  input logic [1:0]        prot_i,
  input logic              arr_we_o,
  input logic [ADDR_W-1:0] arr_addr_o,
  input logic              wip_o,
  input logic              wel_clr_o
);
  AST_WE_NEEDS_WIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_we_o |-> wip_o); // R4
  AST_WE_SAME_PAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_we_o && $past(arr_we_o) |->
      arr_addr_o[ADDR_W-1:OFF_W] == $past(arr_addr_o[ADDR_W-1:OFF_W])); // R2
  AST_WE_ASCENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_we_o && $past(arr_we_o) |->
      arr_addr_o[OFF_W-1:0] == $past(arr_addr_o[OFF_W-1:0]) + 1'b1); // R4
  AST_START_AFTER_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wip_o) |-> $past(cs_rise_i)); // R4
  AST_ALL_PROTECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wip_o) |-> $past(prot_i) != 2'b11); // R9
  AST_WIP_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wip_o && !wel_clr_o |=> wip_o); // R5
  AST_CLR_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wel_clr_o |-> wip_o); // R6
  AST_CLR_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wel_clr_o |=> !wip_o); // R6
endmodule

bind page_write_buf pwb_checks #(.ADDR_W(ADDR_W), .OFF_W($clog2(PAGE_BYTES))) u_chk (
  .clk_i, .rst_ni, .cs_rise_i, .prot_i,
  .arr_we_o, .arr_addr_o, .wip_o, .wel_clr_o
);

// File: tb/sim_page_write_buf.sv
`timescale 1ns/1ps
module sim_page_write_buf;
  localparam int CC = 80;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 0, wen = 0, bvld = 0, csr = 0, algn = 0;
  logic [14:0] addr = '0;
  logic [7:0]  bdat = '0;
  logic [1:0]  prot = '0;
  logic        we, wip, wclr;
  logic [14:0] waddr;
  logic [7:0]  wdata;

  always #10 clk = ~clk; // 50 MHz

  page_write_buf #(.COMMIT_CYCLES(CC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .addr_i(addr), .wen_i(wen),
    .byte_vld_i(bvld), .byte_i(bdat), .cs_rise_i(csr), .aligned_i(algn),
    .prot_i(prot), .arr_we_o(we), .arr_addr_o(waddr), .arr_data_o(wdata),
    .wip_o(wip), .wel_clr_o(wclr)
  );

  int total = 0, bad = 0;
  logic [14:0] log_a [128];
  logic [7:0]  log_d [128];
  int n_log = 0, wip_cyc = 0, wel_n = 0, wel_at = -1;

  always @(negedge clk) if (rst_n) begin
    if (we) begin
      if (n_log < 128) begin log_a[n_log] = waddr; log_d[n_log] = wdata; end
      n_log++;
    end
    if (wip) wip_cyc++;
    if (wclr) begin wel_n++; wel_at = wip_cyc; end
  end

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc; @(posedge clk); #2; endtask
  task automatic clr_log; n_log = 0; wip_cyc = 0; wel_n = 0; wel_at = -1; endtask
  task automatic do_start(input logic [14:0] a, input logic w);
    start = 1; addr = a; wen = w; cyc; start = 0;
  endtask
  task automatic send_byte(input logic [7:0] b);
    bvld = 1; bdat = b; cyc; bvld = 0;
  endtask
  task automatic cs_up(input logic al);
    csr = 1; algn = al; cyc; csr = 0; algn = 0;
  endtask
  task automatic settle; repeat (CC + 10) cyc; endtask

  task automatic t_reset;
    chk("R1 wip", int'(wip), 0);
    chk("R1 we", int'(we), 0);
    chk("R1 wclr", int'(wclr), 0);
  endtask

  task automatic t_basic;
    clr_log; prot = 0;
    do_start(15'h0105, 1);
    send_byte(8'hA1); send_byte(8'hA2); send_byte(8'hA3);
    chk("R4 idle before rise", int'(wip), 0);
    cs_up(1);
    chk("R4 wip next cycle", int'(wip), 1);
    settle;
    chk("R4 count", n_log, 3);
    chk("R2 addr0", int'(log_a[0]), 'h105); chk("R2 data0", int'(log_d[0]), 'hA1);
    chk("R2 addr2", int'(log_a[2]), 'h107); chk("R2 data2", int'(log_d[2]), 'hA3);
    chk("R5 busy cycles", wip_cyc, CC);
    chk("R6 clr pulses", wel_n, 1);
    chk("R6 clr in last busy cycle", wel_at, CC);
  endtask

  task automatic t_wrap;
    clr_log;
    do_start(15'h2ABE, 1);
    send_byte(8'h11); send_byte(8'h22); send_byte(8'h33); send_byte(8'h44);
    cs_up(1); settle;
    chk("R2 wrap count", n_log, 4);
    chk("R2 wrap a0", int'(log_a[0]), 'h2A80); chk("R2 wrap d0", int'(log_d[0]), 'h33);
    chk("R2 wrap a1", int'(log_a[1]), 'h2A81); chk("R2 wrap d1", int'(log_d[1]), 'h44);
    chk("R2 wrap a2", int'(log_a[2]), 'h2ABE); chk("R2 wrap d3", int'(log_d[3]), 'h22);
  endtask

  task automatic t_overflow;
    clr_log;
    do_start(15'h0400, 1);
    for (int i = 0; i < 66; i++) send_byte(8'(i));
    cs_up(1); settle;
    chk("R3 count", n_log, 64);
    chk("R3 off0", int'(log_d[0]), 64);
    chk("R3 off1", int'(log_d[1]), 65);
    chk("R3 off2", int'(log_d[2]), 2);
    chk("R3 off63", int'(log_d[63]), 63);
  endtask

  task automatic t_no_commit(input logic [14:0] a, input logic w, input logic al,
                             input int nb, input string tag);
    clr_log;
    do_start(a, w);
    for (int i = 0; i < nb; i++) send_byte(8'h5C);
    cs_up(al); settle;
    chk({tag, " writes"}, n_log, 0);
    chk({tag, " busy"}, wip_cyc, 0);
  endtask

  task automatic t_prot_pass(input logic [14:0] a, input string tag);
    clr_log;
    do_start(a, 1); send_byte(8'h77); cs_up(1); settle;
    chk({tag, " writes"}, n_log, 1);
    chk({tag, " addr"}, int'(log_a[0]), int'(a));
  endtask

  task automatic t_busy_refuse;
    clr_log;
    do_start(15'h0040, 1); send_byte(8'h5A); cs_up(1);
    do_start(15'h0100, 1); send_byte(8'hEE); cs_up(1);
    settle; repeat (20) cyc;
    chk("R10 writes", n_log, 1);
    chk("R10 addr", int'(log_a[0]), 'h40);
    chk("R10 single commit", wip_cyc, CC);
    chk("R10 idle", int'(wip), 0);
  endtask

  task automatic t_same_cycle;
    clr_log;
    do_start(15'h0200, 1); send_byte(8'h11);
    bvld = 1; bdat = 8'h22; csr = 1; algn = 1; cyc;
    bvld = 0; csr = 0; algn = 0;
    settle;
    chk("R11 count", n_log, 2);
    chk("R11 addr1", int'(log_a[1]), 'h201);
    chk("R11 data1", int'(log_d[1]), 'h22);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    cyc;
    t_reset;
    t_basic;
    t_wrap;
    t_overflow;
    t_no_commit(15'h0300, 0, 1, 2, "R7 wen clear");
    t_no_commit(15'h0300, 1, 0, 2, "R8 misaligned");
    t_no_commit(15'h0300, 1, 1, 0, "R12 empty");
    prot = 2'd1; t_no_commit(15'h6000, 1, 1, 1, "R9 qtr hit");
    t_prot_pass(15'h5FC0, "R9 qtr pass");
    prot = 2'd2; t_no_commit(15'h4000, 1, 1, 1, "R9 half hit");
    t_prot_pass(15'h3FC0, "R9 half pass");
    prot = 2'd3; t_no_commit(15'h0000, 1, 1, 1, "R9 all hit");
    prot = 2'd0;
    t_busy_refuse;
    t_same_cycle;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    total++; bad++;
    $display("FAIL watchdog act=1 exp=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule